// File: doc/BRIEF.md
# Handshaked Byte Shift Port

This block carries single bytes between a host and a power-management microcontroller. The link is a serial shift register whose clock is driven by the microcontroller, plus two active-low wires: a request driven by this block and an acknowledge driven by the peer. The host issues one command per byte on a valid/ready stream. The command names the direction (send or fetch) and, for a send, the byte. The block answers with a single completion beat on a second valid/ready stream. That beat carries the byte just fetched and a flag that marks a peer that never let go of acknowledge.

A byte is not finished when the eighth bit has moved. After the last shift the block lets request go high. It then waits for the peer to raise acknowledge, so the four-phase exchange is fully closed before the host sees completion. That wait has a bound: a fixed number of polling periods, each a fixed number of microseconds, derived from the system clock frequency. Peer clock, acknowledge and serial input are asynchronous, and each passes through a synchronizer.

Back-pressure rules: `cmd_ready` is high only while the port is idle, and a command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. The completion beat holds `rsp_valid`, `rsp_byte` and `rsp_timeout` steady until `rsp_ready` is seen high. No new command is taken until that beat has been consumed. Message framing, byte selection and interrupt routing belong to the host.

Top module: `byte_shift_port`

## Requirements
- R1: While reset is asserted and after its release, `req_n` is high, `cmd_ready` is high, `rsp_valid` is low, `peer_sdo` is high and `rsp_byte` is zero.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both high. On the clock after it is taken, `req_n` is low and `cmd_ready` is low.
- R3: With `cmd_dir`=0 (send), `peer_sdo` presents the byte most significant bit first. The next bit appears after each rising edge of `peer_sclk`. When no send is shifting, `peer_sdo` is high.
- R4: With `cmd_dir`=1 (fetch), the shift register starts cleared. `peer_sdi` is taken at each rising `peer_sclk` edge, first bit as most significant. After eight edges the completion carries the assembled byte in `rsp_byte`.
- R5: A send never changes `rsp_byte`. It keeps the last fetched byte, or zero if no fetch has happened since reset.
- R6: On the eighth peer clock edge the block raises `req_n`. `rsp_valid` does not rise while `ack_n` is still low. Once `ack_n` is high, the completion arrives with `rsp_timeout`=0.
- R7: If `ack_n` stays low for POLL_LIMIT polling periods of POLL_US microseconds after `req_n` is released, the completion arrives with `rsp_timeout`=1. A fetched byte is still reported.
- R8: If `ack_n` is high when the eighth edge completes the shift, `anomaly` pulses high for exactly one cycle and the transfer goes on normally.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_byte` and `rsp_timeout` hold and `cmd_ready` stays low. The cycle after `rsp_ready` is seen, the port is idle again.
- R10: For each cycle that `cmd_valid` is high while `cmd_ready` is low, `proto_err` is high for one cycle, one clock later. The command is not taken during those cycles.
- R11: Rising edges on `peer_sclk` while the port is idle are ignored. A later transfer still takes exactly eight edges and returns the correct byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready (port idle) |
| cmd_dir | input | 1 | 0 = send byte, 1 = fetch byte |
| cmd_byte | input | DATA_W | Byte to send |
| rsp_valid | output | 1 | Completion stream valid |
| rsp_ready | input | 1 | Completion stream ready |
| rsp_byte | output | DATA_W | Last fetched byte |
| rsp_timeout | output | 1 | Peer did not release acknowledge in time |
| anomaly | output | 1 | One-cycle pulse: shift ended with acknowledge high |
| proto_err | output | 1 | Pulse: command offered while busy |
| peer_sclk | input | 1 | Shift clock from the peer |
| peer_sdi | input | 1 | Serial data from the peer |
| peer_sdo | output | 1 | Serial data to the peer |
| req_n | output | 1 | Request to the peer, active low |
| ack_n | input | 1 | Acknowledge from the peer, active low |

## Verification
The bench builds the port with a 250 MHz CLK_HZ, POLL_US=1 and POLL_LIMIT=4, which makes the closing bound about 1000 cycles. A stuck acknowledge can then be run to its timeout and bracketed from both sides within a short run. The byte width and synchronizer depth keep their default values. The peer model holds each half of the shift clock for ten system cycles, so synchronizer latency never hides a bit, and the exact sampling edge is still tested.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CLOSE = 2'd2,
    ST_RESP  = 2'd3
  } bsp_state_e;

  typedef enum logic {
    DIR_SEND  = 1'b0,
    DIR_FETCH = 1'b1
  } bsp_dir_e;
endpackage

// File: rtl/bsp_bit_sync.sv
module bsp_bit_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RESET_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= {STAGES{RESET_VAL}};
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bsp_shift_core.sv
module bsp_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  bsp_pkg::bsp_dir_e load_dir,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              step,
  input  logic              sdi,
  output logic [DATA_W-1:0] shreg,
  output logic              last_step
);
  import bsp_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      shreg   <= (load_dir == DIR_FETCH) ? '0 : load_byte;
      bit_cnt <= '0;
    end else if (step) begin
      shreg   <= {shreg[DATA_W-2:0], sdi};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign last_step = step && (bit_cnt == LAST_IDX);
endmodule

// File: rtl/bsp_close_timer.sv
module bsp_close_timer #(
  parameter int TICK_CYC   = 2500,
  parameter int POLL_LIMIT = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TICK_CYC + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYC - 1);
  localparam logic [PW-1:0] POLL_END  = PW'(POLL_LIMIT);

  logic [TW-1:0] tick_cnt;
  logic [PW-1:0] poll_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      poll_cnt <= '0;
    end else if (!run) begin
      tick_cnt <= '0;
      poll_cnt <= '0;
    end else if (poll_cnt != POLL_END) begin
      if (tick_cnt == TICK_LAST) begin
        tick_cnt <= '0;
        poll_cnt <= poll_cnt + 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  assign expired = run && (poll_cnt == POLL_END);
endmodule

// File: rtl/byte_shift_port.sv
module byte_shift_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_HZ      = 250_000_000,
  parameter int POLL_US     = 10,
  parameter int POLL_LIMIT  = 3200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_dir,
  input  logic [DATA_W-1:0] cmd_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_byte,
  output logic              rsp_timeout,
  output logic              anomaly,
  output logic              proto_err,
  input  logic              peer_sclk,
  input  logic              peer_sdi,
  output logic              peer_sdo,
  output logic              req_n,
  input  logic              ack_n
);
  import bsp_pkg::*;

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int TICK_CYC   = (CYC_PER_US * POLL_US > 0) ? CYC_PER_US * POLL_US : 1;

  bsp_state_e        state;
  bsp_dir_e          dir_q;
  logic              sclk_s, sdi_s, ack_s, sclk_prev;
  logic              sclk_rise, take, step, last_step, expired;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] rsp_byte_q;
  logic              req_n_q, rsp_to_q, anomaly_q, proto_q;

  bsp_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(peer_sclk), .q(sclk_s));
  bsp_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d(peer_sdi), .q(sdi_s));
  bsp_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_ack (
    .clk(clk), .rst_n(rst_n), .d(ack_n), .q(ack_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s && !sclk_prev;
  assign take      = cmd_valid && (state == ST_IDLE);
  assign step      = (state == ST_SHIFT) && sclk_rise;

  bsp_shift_core #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .load_dir  (bsp_dir_e'(cmd_dir)),
    .load_byte (cmd_byte),
    .step      (step),
    .sdi       (sdi_s),
    .shreg     (shreg),
    .last_step (last_step)
  );

  bsp_close_timer #(.TICK_CYC(TICK_CYC), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_CLOSE),
    .expired (expired)
  );

  // Transfer sequencer: idle -> shift -> close -> respond
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      dir_q      <= DIR_SEND;
      req_n_q    <= 1'b1;
      rsp_byte_q <= '0;
      rsp_to_q   <= 1'b0;
      anomaly_q  <= 1'b0;
    end else begin
      anomaly_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            dir_q   <= bsp_dir_e'(cmd_dir);
            req_n_q <= 1'b0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (last_step) begin
            if (dir_q == DIR_FETCH) rsp_byte_q <= {shreg[DATA_W-2:0], sdi_s};
            anomaly_q <= ack_s;
            req_n_q   <= 1'b1;
            state     <= ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if (ack_s) begin
            rsp_to_q <= 1'b0;
            state    <= ST_RESP;
          end else if (expired) begin
            rsp_to_q <= 1'b1;
            state    <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_q <= 1'b0;
    else        proto_q <= cmd_valid && (state != ST_IDLE);
  end

  assign cmd_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_byte    = rsp_byte_q;
  assign rsp_timeout = rsp_to_q;
  assign anomaly     = anomaly_q;
  assign proto_err   = proto_q;
  assign req_n       = req_n_q;
  assign peer_sdo    = (state == ST_SHIFT && dir_q == DIR_SEND) ? shreg[DATA_W-1] : 1'b1;
endmodule

// File: rtl/byte_shift_port_chk.sv
module byte_shift_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_byte,
  input logic              rsp_timeout,
  input logic              anomaly,
  input logic              proto_err,
  input logic              peer_sdo,
  input logic              req_n
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (req_n && cmd_ready && !rsp_valid && peer_sdo));

  // R2
  take_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!req_n && !cmd_ready));

  // R3
  idle_sdo_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> peer_sdo);

  // R6
  rsp_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> req_n);

  // R8
  anomaly_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly |=> !anomaly);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte) && $stable(rsp_timeout)));

  // R9
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && cmd_ready));

  // R10
  proto_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(cmd_valid && !cmd_ready));
endmodule

bind byte_shift_port byte_shift_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
  .rsp_timeout(rsp_timeout), .anomaly(anomaly), .proto_err(proto_err),
  .peer_sdo(peer_sdo), .req_n(req_n)
);

// File: tb/byte_shift_port_tb_top.sv
module byte_shift_port_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cmd_valid = 1'b0, cmd_dir = 1'b0, rsp_ready = 1'b0;
  logic [W-1:0] cmd_byte = '0;
  logic peer_sclk = 1'b0, peer_sdi = 1'b0, ack_n = 1'b1;
  logic cmd_ready, rsp_valid, rsp_timeout, anomaly, proto_err, peer_sdo, req_n;
  logic [W-1:0] rsp_byte;

  int n_chk = 0, n_fail = 0;
  int anom_cnt = 0, proto_cnt = 0;
  bit done = 1'b0;
  logic [W-1:0] last_rx = '0;
  logic [W-1:0] got_byte;

  always #2 clk = ~clk;

  byte_shift_port #(.DATA_W(W), .SYNC_STAGES(2), .CLK_HZ(250_000_000),
                    .POLL_US(1), .POLL_LIMIT(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dir(cmd_dir), .cmd_byte(cmd_byte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_byte(rsp_byte), .rsp_timeout(rsp_timeout),
    .anomaly(anomaly), .proto_err(proto_err), .peer_sclk(peer_sclk),
    .peer_sdi(peer_sdi), .peer_sdo(peer_sdo), .req_n(req_n), .ack_n(ack_n));

  always @(negedge clk) begin
    if (anomaly)   anom_cnt++;
    if (proto_err) proto_cnt++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] expect_byte(input bit dir, input logic [W-1:0] peer_b);
    return dir ? peer_b : last_rx;
  endfunction

  // ack_mode: 0 normal, 1 acknowledge never driven low, 2 acknowledge stuck low
  task automatic do_xfer(input bit dir, input logic [W-1:0] tx_b, input logic [W-1:0] peer_b,
                         input int ack_mode, input int bp, input bit poke);
    int a0, p0, n, bad;
    logic [W-1:0] exp_b;
    logic exp_to;
    while (!cmd_ready) @(negedge clk);
    a0 = anom_cnt;
    cmd_valid = 1'b1; cmd_dir = dir; cmd_byte = tx_b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = W'($urandom);
    chk(req_n == 1'b0, "R2", req_n, 0);
    chk(cmd_ready == 1'b0, "R2", cmd_ready, 0);
    if (ack_mode != 1) ack_n = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      peer_sclk = 1'b0; peer_sdi = peer_b[i];
      repeat (10) @(negedge clk);
      if (!dir) chk(peer_sdo == tx_b[i], "R3", peer_sdo, tx_b[i]);
      if (poke && i == 4) begin
        p0 = proto_cnt;
        cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(proto_cnt - p0 == 3, "R10", proto_cnt - p0, 3);
        chk(req_n == 1'b0, "R10", req_n, 0);
      end
      peer_sclk = 1'b1;
      repeat (10) @(negedge clk);
    end
    n = 0;
    while (req_n == 1'b0 && n < 50) begin @(negedge clk); n++; end
    chk(req_n == 1'b1, "R6", req_n, 1);
    if (!dir) chk(peer_sdo == 1'b1, "R3", peer_sdo, 1);
    if (ack_mode == 0) begin
      bad = 0;
      repeat (20) begin if (rsp_valid) bad++; @(negedge clk); end
      chk(bad == 0, "R6", bad, 0);
      ack_n = 1'b1;
    end else if (ack_mode == 2) begin
      repeat (900) @(negedge clk);
      chk(rsp_valid == 1'b0, "R7", rsp_valid, 0);
    end
    n = 0;
    while (!rsp_valid && n < 1300) begin @(negedge clk); n++; end
    exp_b  = expect_byte(dir, peer_b);
    exp_to = (ack_mode == 2);
    chk(rsp_valid == 1'b1, "R6", rsp_valid, 1);
    if (ack_mode == 2) chk(n < 300, "R7", n, 300);
    chk(rsp_timeout == exp_to, exp_to ? "R7" : "R6", rsp_timeout, exp_to);
    chk(rsp_byte == exp_b, dir ? "R4" : "R5", rsp_byte, exp_b);
    chk(anom_cnt - a0 == (ack_mode == 1 ? 1 : 0), "R8", anom_cnt - a0, ack_mode == 1);
    got_byte = rsp_byte;
    if (dir) last_rx = peer_b;
    bad = 0;
    repeat (bp) begin
      @(negedge clk);
      if (!rsp_valid || rsp_byte != exp_b || rsp_timeout != exp_to || cmd_ready) bad++;
    end
    chk(bad == 0, "R9", bad, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && cmd_ready == 1'b1, "R9", {rsp_valid, cmd_ready}, 1);
    if (ack_mode != 0) begin
      ack_n = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5eed_c0de);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_n == 1'b1 && cmd_ready == 1'b1, "R1", {req_n, cmd_ready}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    chk(peer_sdo == 1'b1, "R1", peer_sdo, 1);
    chk(rsp_byte == '0, "R1", rsp_byte, 0);

    // send before any fetch: completion byte stays zero
    do_xfer(1'b0, 8'hA5, 8'h00, 0, 0, 1'b0);
    do_xfer(1'b1, 8'h00, 8'h3C, 0, 3, 1'b0);
    do_xfer(1'b1, 8'h00, 8'hFF, 0, 0, 1'b0);
    do_xfer(1'b0, 8'h5A, 8'hC3, 0, 5, 1'b1);

    // R11: stray peer clock edges while idle
    repeat (3) begin
      peer_sclk = 1'b0; repeat (8) @(negedge clk);
      peer_sclk = 1'b1; repeat (8) @(negedge clk);
    end
    do_xfer(1'b1, 8'h00, 8'h96, 0, 0, 1'b0);
    chk(got_byte == 8'h96, "R11", got_byte, 8'h96);

    do_xfer(1'b1, 8'h00, 8'h01, 1, 2, 1'b0);   // R8 anomaly path
    do_xfer(1'b1, 8'h00, 8'h81, 2, 1, 1'b0);   // R7 timeout, byte still captured
    do_xfer(1'b0, 8'hFF, 8'h00, 2, 0, 1'b0);   // R7 on send, R5 byte kept
    do_xfer(1'b0, 8'h00, 8'h7E, 0, 0, 1'b0);

    for (int k = 0; k < 16; k++) begin
      do_xfer(1'($urandom), W'($urandom), W'($urandom),
              ($urandom % 5 == 0) ? 1 : 0, int'($urandom % 6), 1'($urandom % 4 == 0));
    end
    finish_run();
  end
endmodule